// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Controller

This block is a unified cache between a requesting core and a 32-bit external memory bus. Its storage is four ways of `SETS` lines, and each line is 16 bytes aligned on a 16-byte boundary. With the default of 128 sets that is 8 KB of data. The set index and the tag both come from the physical address of each request. The block accepts one request per clock while it is idle. A read that hits returns its word in the next cycle and causes no bus activity. A read that misses fetches the whole line in four word beats. A single mode input selects whether a write hit is also sent to memory (write-through) or is only kept in the line (write-back).

A second mode input turns off both caching and forwarding. In that mode the data array is a directly addressed scratch RAM with single-cycle access. The address word field selects the word, the index field selects the set, and the two bits above the index select the way.

The controller is a four-state machine:
- `S_IDLE` accepts requests.
- `S_WR_THRU` carries one forwarded bus write, for a write-through hit or a write miss.
- `S_EVICT` writes a dirty victim back in four beats.
- `S_FILL` reads the new line in four beats.

The transitions are:
- `S_IDLE` to `S_WR_THRU` on a write miss, or on a write hit in write-through mode.
- `S_IDLE` to `S_EVICT` on a read miss whose victim line is dirty.
- `S_IDLE` to `S_FILL` on a read miss whose victim line is clean or invalid.
- `S_EVICT` to `S_FILL` on the acknowledge of beat 3.
- `S_FILL` to `S_IDLE` on the acknowledge of beat 3.
- `S_WR_THRU` to `S_IDLE` on its acknowledge.

Every other state/input combination holds the state.

The bus handshake works as follows. The controller holds `bus_req` together with the address, direction and write data. Memory answers each beat with a single-cycle `bus_ack` pulse, and for a read it presents `bus_rdata` in that same cycle.

Top module: `sa4c_cache_ctrl`

## Requirements
- R1: Address fields are fixed. The word select is addr[3:2] and the set index is addr[4 +: log2(SETS)]. The tag is every bit above the set index. Two lines with the same set index and different tags are separate lines: reading one never hits on the other, and at most one way matches a lookup.
- R2: After reset, `req_ready`=1, `resp_valid`=0 and `bus_req`=0. A read hit accepted at a clock edge raises `resp_valid` with the stored word in the following cycle, with no bus cycle. Hits can be issued in consecutive clocks, and each one is answered in the cycle after it.
- R3: A read miss performs four read beats at line addresses +0, +4, +8, +12, in that order. The line becomes valid after the last beat. `resp_valid` rises in the cycle after the last acknowledge and carries the requested word.
- R4: In write-through mode (`mode_wb`=0), a write hit updates the line and issues exactly one bus write of the word to its address. The response follows that acknowledge.
- R5: In write-back mode (`mode_wb`=1), a write hit updates the line, causes no bus cycle, responds in the next cycle and marks the line dirty.
- R6: A write miss issues one bus write and allocates no line, so a later read of the same address misses and fills.
- R7: With `mode_ram`=1, reads and writes reach the data array directly and cause no bus traffic. The array index is way = addr[4+log2(SETS) +: 2], set = the index field, word = addr[3:2]. Higher address bits are ignored, and every access responds in the next cycle.
- R8: On a miss, the victim is the lowest-numbered invalid way. If all ways are valid, the victim is chosen by a 3-bit tree per set:
  - bit0 = 1 selects ways 2/3.
  - bit1 = 1 selects way 1 over way 0.
  - bit2 = 1 selects way 3 over way 2.
  - Each hit and fill points the tree away from the way it used.
- R9: A dirty victim is written out as four ascending write beats to its own line address before the first fill beat. Memory then holds the data that was written into that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wb | input | 1 | 1 = write-back, 0 = write-through for write hits |
| mode_ram | input | 1 | 1 = caching and forwarding off, data array used as scratch RAM |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical byte address (word aligned) |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Controller idle; a valid request is taken at this edge |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read word (zero for writes) |
| bus_req | output | 1 | Bus beat requested |
| bus_write | output | 1 | 1 = bus write beat |
| bus_addr | output | ADDR_W | Word address of the beat |
| bus_wdata | output | DATA_W | Write data of the beat |
| bus_ack | input | 1 | One-cycle beat acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
The bench builds the controller with `SETS`=4, so the tag starts at address bit 6 and the scratch RAM has only 64 words. With four sets, five tags on one set force replacement quickly, and the bench can predict each victim choice and each dirty write-back directly from the tree rules. A 256-word read/write sweep in write-back mode repeatedly cycles 16 tags through every set, which exercises many evictions. A full 64-word sweep in scratch-RAM mode then checks every array location and the aliasing of higher address bits.

// File: rtl/sa4c_pkg.sv
`timescale 1ns/1ps
package sa4c_pkg;
    localparam int WAYS       = 4;
    localparam int WAY_W      = 2;
    localparam int LINE_WORDS = 4;
    localparam int WORD_W     = 2;
    localparam int BYTE_OFF   = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WR_THRU,
        S_EVICT,
        S_FILL
    } state_t;
endpackage

// File: rtl/sa4c_plru.sv
`timescale 1ns/1ps
module sa4c_plru #(
    parameter int SETS = 128,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [1:0]       victim,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [1:0]       upd_way
);
    logic [2:0] tree_q [SETS];
    logic [2:0] cur_bits;
    logic [2:0] nxt_bits;
    logic [2:0] rd_bits;

    always_comb begin
        cur_bits    = tree_q[upd_set];
        nxt_bits    = cur_bits;
        nxt_bits[0] = ~upd_way[1];
        if (!upd_way[1]) nxt_bits[1] = ~upd_way[0];
        else             nxt_bits[2] = ~upd_way[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[upd_set] <= nxt_bits;
        end
    end

    assign rd_bits = tree_q[rd_set];
    assign victim  = rd_bits[0] ? {1'b1, rd_bits[2]} : {1'b0, rd_bits[1]};

    // R8: after an update, the tree of that set no longer points at the used way
    p_victim_away_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((rd_set != $past(upd_set)) || (victim != $past(upd_way))));
endmodule

// File: rtl/sa4c_tags.sv
`timescale 1ns/1ps
module sa4c_tags #(
    parameter int SETS  = 128,
    parameter int TAG_W = 21,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            lk_set,
    input  logic [TAG_W-1:0]            lk_tag,
    output logic [3:0]                  hit_vec,
    output logic [3:0]                  valid_vec,
    output logic [3:0]                  dirty_vec,
    output logic [3:0][TAG_W-1:0]       way_tag,
    input  logic                        fill_en,
    input  logic [SET_W-1:0]            fill_set,
    input  logic [1:0]                  fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        mark_en,
    input  logic [SET_W-1:0]            mark_set,
    input  logic [1:0]                  mark_way
);
    logic [TAG_W-1:0] tag_q [SETS][4];
    logic [3:0]       vld_q [SETS];
    logic [3:0]       drt_q [SETS];

    assign valid_vec = vld_q[lk_set];
    assign dirty_vec = drt_q[lk_set];

    for (genvar w = 0; w < 4; w++) begin : g_way
        assign way_tag[w] = tag_q[lk_set][w];
        assign hit_vec[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                drt_q[s] <= '0;
            end
        end else begin
            if (mark_en) drt_q[mark_set][mark_way] <= 1'b1;
            if (fill_en) begin
                vld_q[fill_set][fill_way] <= 1'b1;
                drt_q[fill_set][fill_way] <= 1'b0;
            end
        end
    end

    // R1: a lookup matches at most one way
    p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/sa4c_data.sv
`timescale 1ns/1ps
module sa4c_data #(
    parameter int SETS   = 128,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int A_W   = SET_W + 4,
    localparam int DEPTH = SETS * 16
) (
    input  logic              clk,
    input  logic [A_W-1:0]    addr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sa4c_cache_ctrl.sv
`timescale 1ns/1ps
module sa4c_cache_ctrl import sa4c_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - SET_W - BYTE_OFF,
    localparam int ARR_W = WAY_W + SET_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wb,
    input  logic              mode_ram,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam logic [1:0] LAST_BEAT = 2'(LINE_WORDS - 1);

    state_t state_q, state_d;

    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic [WAY_W-1:0]  lat_way_q;
    logic [TAG_W-1:0]  vic_tag_q;
    logic [1:0]        beat_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;

    // address fields
    logic [SET_W-1:0]  req_set, lat_set;
    logic [TAG_W-1:0]  req_tag, lat_tag;
    logic [WORD_W-1:0] req_word, lat_word;
    logic [WAY_W-1:0]  ram_way;
    logic              unused_lsb;

    assign req_set    = req_addr[BYTE_OFF +: SET_W];
    assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
    assign req_word   = req_addr[2 +: WORD_W];
    assign ram_way    = req_addr[BYTE_OFF+SET_W +: WAY_W];
    assign lat_set    = lat_addr_q[BYTE_OFF +: SET_W];
    assign lat_tag    = lat_addr_q[ADDR_W-1 -: TAG_W];
    assign lat_word   = lat_addr_q[2 +: WORD_W];
    assign unused_lsb = ^{req_addr[1:0], lat_addr_q[1:0]};

    // lookup
    logic [3:0]             hit_vec, valid_vec, dirty_vec;
    logic [3:0][TAG_W-1:0]  way_tag;
    logic                   hit;
    logic [WAY_W-1:0]       hit_way, plru_victim, vic_way;
    logic                   vic_dirty;

    // array and bookkeeping controls
    logic [ARR_W-1:0]  arr_addr;
    logic [DATA_W-1:0] arr_rdata, arr_wdata;
    logic              arr_we;
    logic              fill_en, mark_en, plru_en;
    logic [SET_W-1:0]  plru_set;
    logic [WAY_W-1:0]  plru_way;

    // request classes in S_IDLE
    logic accept, acc_ram, acc_hit, rd_miss, wr_miss, wt_hit, last_ack;

    assign hit       = |hit_vec;
    assign accept    = req_valid && (state_q == S_IDLE);
    assign acc_ram   = accept && mode_ram;
    assign acc_hit   = accept && !mode_ram && hit;
    assign rd_miss   = accept && !mode_ram && !hit && !req_write;
    assign wr_miss   = accept && !mode_ram && !hit && req_write;
    assign wt_hit    = acc_hit && req_write && !mode_wb;
    assign last_ack  = bus_ack && (beat_q == LAST_BEAT);
    assign vic_dirty = valid_vec[vic_way] && dirty_vec[vic_way];

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    always_comb begin
        vic_way = plru_victim;
        for (int w = WAYS - 1; w >= 0; w--) if (!valid_vec[w]) vic_way = WAY_W'(w);
    end

    sa4c_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(req_set), .lk_tag(req_tag),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec), .way_tag(way_tag),
        .fill_en(fill_en), .fill_set(lat_set), .fill_way(lat_way_q), .fill_tag(lat_tag),
        .mark_en(mark_en), .mark_set(req_set), .mark_way(hit_way)
    );

    sa4c_plru #(.SETS(SETS)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .rd_set(req_set), .victim(plru_victim),
        .upd_en(plru_en), .upd_set(plru_set), .upd_way(plru_way)
    );

    sa4c_data #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .addr(arr_addr), .rdata(arr_rdata),
        .we(arr_we), .wdata(arr_wdata)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (wr_miss || wt_hit)  state_d = S_WR_THRU;
                else if (rd_miss)       state_d = vic_dirty ? S_EVICT : S_FILL;
            end
            S_WR_THRU: if (bus_ack)  state_d = S_IDLE;
            S_EVICT:   if (last_ack) state_d = S_FILL;
            S_FILL:    if (last_ack) state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and array controls
    always_comb begin
        req_ready = 1'b0;
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        arr_addr  = {lat_way_q, lat_set, beat_q};
        arr_we    = 1'b0;
        arr_wdata = req_wdata;
        fill_en   = 1'b0;
        mark_en   = 1'b0;
        plru_en   = 1'b0;
        plru_set  = lat_set;
        plru_way  = lat_way_q;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                arr_addr  = {mode_ram ? ram_way : hit_way, req_set, req_word};
                arr_we    = (acc_ram || acc_hit) && req_write;
                mark_en   = acc_hit && req_write && mode_wb;
                plru_en   = acc_hit;
                plru_set  = req_set;
                plru_way  = hit_way;
            end
            S_WR_THRU: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {lat_addr_q[ADDR_W-1:2], 2'b00};
                bus_wdata = lat_wdata_q;
            end
            S_EVICT: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_addr  = {vic_tag_q, lat_set, beat_q, 2'b00};
                bus_wdata = arr_rdata;
            end
            S_FILL: begin
                bus_req   = 1'b1;
                bus_addr  = {lat_tag, lat_set, beat_q, 2'b00};
                arr_we    = bus_ack;
                arr_wdata = bus_rdata;
                fill_en   = last_ack;
                plru_en   = last_ack;
            end
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr_q   <= '0;
            lat_wdata_q  <= '0;
            lat_way_q    <= '0;
            vic_tag_q    <= '0;
            beat_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        lat_addr_q  <= req_addr;
                        lat_wdata_q <= req_wdata;
                        lat_way_q   <= vic_way;
                        vic_tag_q   <= way_tag[vic_way];
                        beat_q      <= '0;
                        if (mode_ram || (hit && !(req_write && !mode_wb))) begin
                            resp_valid_q <= 1'b1;
                            resp_data_q  <= req_write ? '0 : arr_rdata;
                        end
                    end
                end
                S_WR_THRU: begin
                    if (bus_ack) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= '0;
                    end
                end
                S_EVICT: begin
                    if (bus_ack) beat_q <= beat_q + 2'd1;
                end
                S_FILL: begin
                    if (bus_ack) begin
                        beat_q <= beat_q + 2'd1;
                        if (beat_q == lat_word) resp_data_q <= bus_rdata;
                        if (beat_q == LAST_BEAT) resp_valid_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_data_q;

    // R2: a read hit answers next cycle without touching the bus
    p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mode_ram && hit && !req_write) |=> (resp_valid && !bus_req && req_ready));
    // R3: the last fill acknowledge completes the read
    p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && last_ack) |=> (resp_valid && req_ready));
    // R4: write-through hit forwards the same word address
    p_wt_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && req_write && !mode_wb) |=>
        (bus_req && bus_write && bus_addr[ADDR_W-1:2] == $past(req_addr[ADDR_W-1:2])));
    // R5: write-back hit stays off the bus
    p_wb_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && req_write && mode_wb) |=> (!bus_req && resp_valid));
    // R6: write miss goes straight to a single forwarded write
    p_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_miss |=> (state_q == S_WR_THRU && bus_write));
    // R7: scratch-RAM accesses never use the bus
    p_ram_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ram |=> (!bus_req && resp_valid));
    // R9: a fill starts only from idle or after the fourth eviction beat
    p_evict_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) != S_FILL) |->
        ($past(state_q) == S_IDLE || $past(beat_q) == LAST_BEAT));
endmodule

// File: tb/sa4c_cache_ctrl_tb.sv
`timescale 1ns/1ps
module sa4c_cache_ctrl_tb;
    localparam int SETS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wb = 1'b0, mode_ram = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    sa4c_cache_ctrl #(.SETS(SETS)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wb(mode_wb), .mode_ram(mode_ram),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction

    // memory model: one-cycle acknowledge pulse per beat
    logic [31:0] mem [1024];
    logic [32:0] elog [64];
    int rd_cnt, wr_cnt, eptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
            bus_ack <= 1'b0; bus_rdata <= '0;
            rd_cnt <= 0; wr_cnt <= 0; eptr <= 0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            elog[eptr[5:0]] <= {bus_write, bus_addr};
            eptr <= eptr + 1;
            if (bus_write) begin
                mem[bus_addr[11:2]] <= bus_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                bus_rdata <= mem[bus_addr[11:2]];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    logic [31:0] shadow [1024];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        logic acc;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        acc = 1'b0;
        while (!acc) begin
            acc = req_ready;
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        rd = resp_rdata;
    endtask

    // cached read, data and bus beats checked
    task automatic rd_chk(input string tag, input logic [31:0] a, input int exp_rd, input int exp_wr);
        logic [31:0] d;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b0, a, '0, d);
        chk({tag, " data"}, {1'b0, d}, {1'b0, shadow[a[11:2]]});
        chk({tag, " read beats"}, 33'(rd_cnt - r0), 33'(exp_rd));
        chk({tag, " write beats"}, 33'(wr_cnt - w0), 33'(exp_wr));
    endtask

    task automatic wr_do(input string tag, input logic [31:0] a, input logic [31:0] v,
                         input int exp_wr);
        logic [31:0] d;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b1, a, v, d);
        shadow[a[11:2]] = v;
        chk({tag, " write beats"}, 33'(wr_cnt - w0), 33'(exp_wr));
        chk({tag, " read beats"}, 33'(rd_cnt - r0), 33'd0);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int e0, r0, w0;
        logic [31:0] d;
        for (int i = 0; i < 1024; i++) shadow[i] = pat(i);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset ready", {32'd0, req_ready}, 33'd1);
        chk("R2 reset resp_valid", {32'd0, resp_valid}, 33'd0);
        chk("R2 reset bus_req", {32'd0, bus_req}, 33'd0);

        // R3: read miss fills ascending
        e0 = eptr;
        rd_chk("R3 miss 0x018", 32'h018, 4, 0);
        for (int k = 0; k < 4; k++)
            chk("R3 fill order", elog[6'(e0 + k)], {1'b0, 32'h010 + 32'(4 * k)});

        // R2: hit and back-to-back hits
        rd_chk("R2 hit 0x010", 32'h010, 0, 0);
        r0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h010;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 pipelined resp_valid", {32'd0, resp_valid}, 33'd1);
            chk("R2 pipelined data", {1'b0, resp_rdata}, {1'b0, pat(4 + k)});
            if (k < 3) req_addr = 32'h010 + 32'(4 * (k + 1));
            else       req_valid = 1'b0;
        end
        chk("R2 pipelined no bus", 33'(rd_cnt - r0), 33'd0);

        // R4: write-through hit
        e0 = eptr;
        wr_do("R4 wt hit", 32'h014, 32'h1111_2222, 1);
        chk("R4 memory updated", {1'b0, mem[5]}, {1'b0, 32'h1111_2222});
        chk("R4 bus address", elog[6'(e0)], {1'b1, 32'h014});
        rd_chk("R4 readback", 32'h014, 0, 0);

        // R5: write-back hit
        @(negedge clk); mode_wb = 1'b1;
        wr_do("R5 wb hit", 32'h018, 32'h3333_4444, 0);
        chk("R5 memory untouched", {1'b0, mem[6]}, {1'b0, pat(6)});
        rd_chk("R5 readback", 32'h018, 0, 0);

        // R6: write miss, no allocation
        wr_do("R6 write miss", 32'h024, 32'h5555_6666, 1);
        chk("R6 memory updated", {1'b0, mem[9]}, {1'b0, 32'h5555_6666});
        rd_chk("R6 later read misses", 32'h024, 4, 0);

        // R9: dirty victim (0x010 line, way 0 of set 1) written back before fill
        rd_chk("R9 fill way1", 32'h050, 4, 0);
        rd_chk("R9 fill way2", 32'h090, 4, 0);
        rd_chk("R9 fill way3", 32'h0D0, 4, 0);
        e0 = eptr;
        rd_chk("R9 evicting miss", 32'h110, 4, 4);
        for (int k = 0; k < 4; k++)
            chk("R9 writeback order", elog[6'(e0 + k)], {1'b1, 32'h010 + 32'(4 * k)});
        for (int k = 0; k < 4; k++)
            chk("R9 fill after writeback", elog[6'(e0 + 4 + k)], {1'b0, 32'h110 + 32'(4 * k)});
        chk("R9 memory holds dirty word", {1'b0, mem[6]}, {1'b0, 32'h3333_4444});

        // R8 and R1: replacement in set 0
        rd_chk("R8 fill way0", 32'h000, 4, 0);
        rd_chk("R8 fill way1", 32'h040, 4, 0);
        rd_chk("R8 fill way2", 32'h080, 4, 0);
        rd_chk("R8 fill way3", 32'h0C0, 4, 0);
        rd_chk("R1 other tag same set misses", 32'h100, 4, 0);
        rd_chk("R8 way1 kept", 32'h044, 0, 0);
        rd_chk("R8 way0 was victim", 32'h000, 4, 0);
        rd_chk("R8 way3 kept", 32'h0C8, 0, 0);
        rd_chk("R8 way2 was victim", 32'h080, 4, 0);
        rd_chk("R8 way1 still kept", 32'h04C, 0, 0);

        // R1 R3 R9: sweep across 16 tags per set in write-back mode
        for (int i = 0; i < 256; i++) begin
            access(1'b0, 32'(i * 4), '0, d);
            chk("R1 sweep read", {1'b0, d}, {1'b0, shadow[i]});
            if (i % 5 == 0) begin
                access(1'b1, 32'(i * 4), pat(i) ^ 32'hFFFF_0000, d);
                shadow[i] = pat(i) ^ 32'hFFFF_0000;
            end
        end
        for (int i = 255; i >= 0; i--) begin
            access(1'b0, 32'(i * 4), '0, d);
            chk("R9 sweep reread", {1'b0, d}, {1'b0, shadow[i]});
        end

        // R7: scratch RAM over all 64 words
        @(negedge clk); mode_ram = 1'b1;
        r0 = rd_cnt; w0 = wr_cnt;
        for (int i = 0; i < 64; i++)
            access(1'b1, 32'(i * 4), 32'h7000_0000 + 32'(i * i), d);
        for (int i = 0; i < 64; i++) begin
            access(1'b0, 32'(i * 4) | 32'h400, '0, d);
            chk("R7 ram readback", {1'b0, d}, {1'b0, 32'h7000_0000 + 32'(i * i)});
        end
        chk("R7 no bus reads", 33'(rd_cnt - r0), 33'd0);
        chk("R7 no bus writes", 33'(wr_cnt - w0), 33'd0);

        summary();
    end
endmodule